// File: doc/BRIEF.md
# Status Flag Update Unit

This unit keeps the negative, zero and carry status bits of a small 8-bit processor datapath. Microcode strobes decide, cycle by cycle, whether the sign and zero bits are reloaded from the value on the internal bus, and whether the carry bit is reloaded. The carry can come from the arithmetic unit's carry-out or from a shift register tap. The arithmetic carry-out arrives active-low. The shift taps are the most significant bit, used before a left shift, and the least significant bit, used before a right shift.

A compare is a two-step microcode sequence. The first step forces the carry to one. The second step subtracts and loads all three flags, and nothing is written back to any register. A borrow clears the carry, an equal result sets zero, and a result with its top bit set sets negative. Overflow is not produced here. Deriving it from the two nibble carry-outs would be wrong: an increment from 0x0F to 0x10 would wrongly report it.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears the negative, zero and carry flags at the next rising edge.
- R2: When nz_load is high at a rising edge, flag_n takes bit 7 of bus_val.
- R3: When nz_load is high at a rising edge, flag_z becomes 1 if all 8 bits of bus_val are zero and 0 otherwise.
- R4: When nz_load is low, flag_n and flag_z keep their values, whatever bus_val holds.
- R5: When c_load is high and c_from_shift is 0, flag_c takes the inverse of the active-low carry_out_n (carry_out_n = 0 gives flag_c = 1).
- R6: When c_load is high and c_from_shift is 1, flag_c takes shift_msb if shift_right is 0 and shift_lsb if shift_right is 1.
- R7: When c_load, c_set and c_clear are all low, flag_c keeps its value.
- R8: c_set forces flag_c to 1 and c_clear forces it to 0, whatever c_load and the data source are doing. If both are high, c_set wins.
- R9: A compare, done as c_set followed by a subtract with c_load and nz_load high, leaves C = 1 when the register is greater than or equal to the operand and C = 0 on a borrow. For example, 0x40 against 0x40 gives Z = 1, C = 1, N = 0, and 0x40 against 0x50 gives N = 1, Z = 0, C = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_val | input | 8 | Value evaluated for the negative and zero flags |
| carry_out_n | input | 1 | Active-low carry-out of the upper arithmetic nibble |
| shift_msb | input | 1 | Shift register bit 7 tap |
| shift_lsb | input | 1 | Shift register bit 0 tap |
| nz_load | input | 1 | Load strobe for negative and zero |
| c_load | input | 1 | Load strobe for carry |
| c_from_shift | input | 1 | Carry source: 0 arithmetic carry, 1 shift tap |
| shift_right | input | 1 | Shift tap choice: 0 MSB, 1 LSB |
| c_set | input | 1 | Force carry to 1 |
| c_clear | input | 1 | Force carry to 0 |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Each flag is one register stage, so every result is due at the first rising edge after the stimulus that causes it. The driver applies inputs on a falling edge and pushes the expected flag triple into a queue. The monitor pops the triple one time unit after the next rising edge and compares it there. Because of this, one queue entry stands for exactly one clock of stimulus. Hold cases are checked by pushing an unchanged expectation while the data inputs toggle.

// File: rtl/status_flag_unit.sv
module status_flag_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] bus_val,
  input  logic       carry_out_n,
  input  logic       shift_msb,
  input  logic       shift_lsb,
  input  logic       nz_load,
  input  logic       c_load,
  input  logic       c_from_shift,
  input  logic       shift_right,
  input  logic       c_set,
  input  logic       c_clear,
  output logic       flag_n,
  output logic       flag_z,
  output logic       flag_c
);

  logic shift_bit;
  logic c_data;

  assign shift_bit = shift_right ? shift_lsb : shift_msb;
  assign c_data    = c_from_shift ? shift_bit : ~carry_out_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (nz_load) begin
      flag_n <= bus_val[7];
      flag_z <= (bus_val == 8'h00);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_c <= 1'b0;
    else if (c_set)   flag_c <= 1'b1;
    else if (c_clear) flag_c <= 1'b0;
    else if (c_load)  flag_c <= c_data;
  end

  // R2
  n_from_bus_chk: assert property (@(posedge clk) disable iff (rst)
    nz_load |=> flag_n == $past(bus_val[7]));

  // R3
  z_from_bus_chk: assert property (@(posedge clk) disable iff (rst)
    nz_load |=> flag_z == ($past(bus_val) == 8'h00));

  // R4
  nz_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !nz_load |=> $stable({flag_n, flag_z}));

  // R5
  c_alu_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (c_load && !c_set && !c_clear && !c_from_shift) |=> flag_c == !$past(carry_out_n));

  // R7
  c_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!c_load && !c_set && !c_clear) |=> $stable(flag_c));

  // R8
  c_set_chk: assert property (@(posedge clk) disable iff (rst)
    c_set |=> flag_c);

  // R8
  c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (c_clear && !c_set) |=> !flag_c);

endmodule

// File: tb/sim_status_flag_unit.sv
module sim_status_flag_unit;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic [7:0] bus_val;
  logic carry_out_n, shift_msb, shift_lsb;
  logic nz_load, c_load, c_from_shift, shift_right, c_set, c_clear;
  logic flag_n, flag_z, flag_c;

  int checks = 0;
  int fails = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];
  logic en = 1'b0, ez = 1'b0, ec = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_unit u0 (
    .clk(clk), .rst(rst), .bus_val(bus_val), .carry_out_n(carry_out_n),
    .shift_msb(shift_msb), .shift_lsb(shift_lsb), .nz_load(nz_load),
    .c_load(c_load), .c_from_shift(c_from_shift), .shift_right(shift_right),
    .c_set(c_set), .c_clear(c_clear),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c));

  task automatic drive(input logic r, input logic [7:0] bv, input logic con,
                       input logic msb, input logic lsb, input logic lnz,
                       input logic lc, input logic fsh, input logic sr,
                       input logic s, input logic cl, input string tag);
    @(negedge clk);
    rst = r; bus_val = bv; carry_out_n = con; shift_msb = msb; shift_lsb = lsb;
    nz_load = lnz; c_load = lc; c_from_shift = fsh; shift_right = sr;
    c_set = s; c_clear = cl;
    if (r) begin
      en = 0; ez = 0; ec = 0;
    end else begin
      if (lnz) begin en = bv[7]; ez = (bv == 8'h00); end
      if (s) ec = 1;
      else if (cl) ec = 0;
      else if (lc) ec = fsh ? (sr ? lsb : msb) : ~con;
    end
    exp_q.push_back({en, ez, ec});
    tag_q.push_back(tag);
  endtask

  task automatic compare(input logic [7:0] reg_v, input logic [7:0] opnd, input string tag);
    logic [8:0] sum;
    drive(0, 8'hA5, 1, 0, 0, 0, 0, 0, 0, 1, 0, tag);
    sum = {1'b0, reg_v} + {1'b0, ~opnd} + 9'd1;
    drive(0, sum[7:0], ~sum[8], 0, 0, 1, 1, 0, 0, 0, 0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({flag_n, flag_z, flag_c} !== e) begin
          fails++;
          $display("FAIL %s: got NZC=%b expected %b", t, {flag_n, flag_z, flag_c}, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    drive(1, 8'hFF, 0, 1, 1, 1, 1, 0, 0, 1, 0, "R1 reset");
    drive(1, 8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
    drive(0, 8'h80, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R2 negative");
    drive(0, 8'h00, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R3 zero");
    drive(0, 8'h7F, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R2 R3 positive");
    drive(0, 8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 hold on zero");
    drive(0, 8'hC3, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 hold on negative");
    drive(0, 8'h01, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 alu carry low");
    drive(0, 8'h01, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R5 alu carry high");
    drive(0, 8'h01, 1, 1, 0, 0, 1, 1, 0, 0, 0, "R6 msb tap");
    drive(0, 8'h01, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 hold");
    drive(0, 8'h01, 0, 1, 0, 0, 1, 1, 1, 0, 0, "R6 lsb tap");
    drive(0, 8'h01, 1, 0, 1, 0, 1, 1, 1, 0, 0, "R6 lsb tap set");
    drive(0, 8'h01, 1, 1, 1, 0, 0, 1, 0, 0, 0, "R7 hold with source");
    drive(0, 8'h01, 0, 1, 1, 0, 1, 0, 0, 0, 1, "R8 clear over data");
    drive(0, 8'h01, 1, 0, 0, 0, 1, 0, 0, 1, 0, "R8 set over data");
    drive(0, 8'h01, 1, 0, 0, 0, 0, 0, 0, 1, 1, "R8 set wins");
    drive(0, 8'h01, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R8 clear");
    compare(8'h40, 8'h40, "R9 equal");
    compare(8'h40, 8'h50, "R9 borrow");
    compare(8'h40, 8'h30, "R9 greater");
    compare(8'h00, 8'hFF, "R9 wrap borrow");
    compare(8'hFF, 8'h00, "R9 max");
    drive(0, 8'h10, 1, 0, 0, 1, 1, 0, 0, 0, 0, "R3 R5 increment 0x0F to 0x10");
    drive(1, 8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset again");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule